// File: doc/BRIEF.md
# Non-blocking data cache with one outstanding line fill

This block is a small direct-mapped data cache that sits between a load/store unit and two memory ports. One port reaches cacheable memory. It fills a whole line as a burst of beats and takes single-word write-through stores. The other port reaches non-cacheable memory one word at a time. A cacheable load that misses reserves its line and launches a fill. Only one fill can be outstanding at a time.

While that fill is running, the requester is not blocked. Loads that hit other valid lines are answered, uncached accesses pass straight through, and stores to other lines write through. Each load carries an ID that comes back with its response. This lets the missed load complete after younger hits. The requester is held off in three cases: a second cacheable load miss, any cacheable access to the line being filled, and the single cycle in which the final fill beat arrives. A held-off miss is accepted in the cycle after its predecessor's line becomes valid, and its own fill is launched in that same cycle.

Addresses are word addresses. The lowest `log2(WORDS)` bits select the word in a line, the next `log2(LINES)` bits select the line, and the remaining bits form the tag.

Top module: `nb_dcache`

## Requirements
- R1: After reset no line is valid, `req_ready` is 1 and `rsp_valid` is 0, so the first cacheable load misses.
- R2: A cacheable load that hits a valid line is accepted without stall. This holds even while a fill is outstanding. One cycle after acceptance, `rsp_valid` is 1 with the request's ID and the stored word.
- R3: A cacheable load that misses while no fill is outstanding is accepted. In the same cycle `fill_req` pulses with `fill_addr` equal to the request address with its word-offset bits cleared. Fill beats are taken in word-offset order 0, 1, 2, 3, one per cycle in which `fill_beat_valid` is 1.
- R4: In the cycle after the final beat, `rsp_valid` is 1 with the missed load's ID and the requested word, and the line is valid from then on.
- R5: `req_ready` is 0 in every cycle in which the final beat of a fill is presented.
- R6: A cacheable load miss presented while a fill is outstanding keeps `req_ready` at 0. It is accepted in the cycle after the outstanding fill completes, and its own `fill_req` pulses in that same cycle.
- R7: While a fill is outstanding, any cacheable load or store whose line index equals the line being filled is held off until the fill completes.
- R8: A request with `req_cacheable` = 0 is never held off by a fill. In its accept cycle `nc_valid` is 1 with the address, direction and write data. For a load, `rsp_valid` is 1 one cycle later and `rsp_rdata` equals `nc_rdata` in that cycle.
- R9: A cacheable store that hits updates the cached word and drives `cm_wr_valid` in its accept cycle. It produces no response and launches no fill.
- R10: A cacheable store that misses drives only `cm_wr_valid` and never launches a fill. The line stays invalid, so a later load of that address misses.
- R11: Every load receives exactly one response carrying its own ID. The response of a missed load may follow the responses of younger loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | 1 = cacheable space, 0 = uncached port |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_id | input | ID_W | Load identifier |
| rsp_valid | output | 1 | Load response present |
| rsp_id | output | ID_W | Identifier of the answered load |
| rsp_rdata | output | DATA_W | Load data |
| fill_req | output | 1 | Pulse launching a line fill |
| fill_addr | output | ADDR_W | Line base word address of the fill |
| fill_beat_valid | input | 1 | Fill beat present |
| fill_beat_data | input | DATA_W | Fill beat data |
| cm_wr_valid | output | 1 | Write-through store to cacheable memory |
| cm_wr_addr | output | ADDR_W | Store word address |
| cm_wr_data | output | DATA_W | Store data |
| nc_valid | output | 1 | Uncached access |
| nc_write | output | 1 | Uncached access direction, 1 = write |
| nc_addr | output | ADDR_W | Uncached word address |
| nc_wdata | output | DATA_W | Uncached write data |
| nc_rdata | input | DATA_W | Uncached read data, valid the cycle after the access |

## Verification
The bench builds the block with its defaults: 16 lines of 4 words, 12-bit word addresses and 4-bit IDs. With these values the tag is only 6 bits, so two addresses that share line index 1 but differ in tag are easy to choose. That makes a second miss to an aliasing line, and a store to the line under fill, easy to stage. The bench memory waits three cycles before the four beats of a fill. Each fill therefore leaves a seven-cycle window in which hits, uncached loads, conflicting stores and a stalled second miss can be placed and their response order observed.

// File: rtl/nb_dcache_pkg.sv
package nb_dcache_pkg;
  typedef enum logic {
    FILL_IDLE  = 1'b0,
    FILL_BEATS = 1'b1
  } fill_st_e;
endpackage

// File: rtl/ndc_arrays.sv
module ndc_arrays #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [OFF_W-1:0]  lk_off,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_valid,
  output logic [DATA_W-1:0] lk_data,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [DATA_W-1:0] st_data,
  input  logic              fb_we,
  input  logic [IDX_W-1:0]  fb_idx,
  input  logic [OFF_W-1:0]  fb_off,
  input  logic [DATA_W-1:0] fb_data,
  input  logic              al_we,
  input  logic [IDX_W-1:0]  al_idx,
  input  logic [TAG_W-1:0]  al_tag,
  input  logic              sv_we,
  input  logic [IDX_W-1:0]  sv_idx
);
  localparam int ENTRIES = LINES * WORDS;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [ENTRIES];

  always_comb begin
    valid_d = valid_q;
    if (al_we) valid_d[al_idx] = 1'b0;
    if (sv_we) valid_d[sv_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              valid_q <= '0;
    else if (al_we || sv_we) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (al_we) tag_q[al_idx] <= al_tag;
  end

  always_ff @(posedge clk) begin
    if (st_we) data_q[{st_idx, st_off}] <= st_data;
    if (fb_we) data_q[{fb_idx, fb_off}] <= fb_data;
  end

  assign lk_tag   = tag_q[lk_idx];
  assign lk_valid = valid_q[lk_idx];
  assign lk_data  = data_q[{lk_idx, lk_off}];

  // R7
  store_fill_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && fb_we) |-> (st_idx != fb_idx));

  // R4
  alloc_set_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_we |-> !al_we);
endmodule

// File: rtl/ndc_fill.sv
module ndc_fill
  import nb_dcache_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [ID_W-1:0]   start_id,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              busy,
  output logic [IDX_W-1:0]  line_idx,
  output logic              beat_we,
  output logic [OFF_W-1:0]  beat_off,
  output logic              last,
  output logic [ID_W-1:0]   miss_id,
  output logic [DATA_W-1:0] miss_word
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  fill_st_e          st_q, st_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] word_q;
  logic              take;

  assign take = (st_q == FILL_BEATS) && beat_valid;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (start) begin
      st_d  = FILL_BEATS;
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_OFF) begin
        st_d  = FILL_IDLE;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FILL_IDLE;
      cnt_q <= '0;
    end else if (start || take) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      idx_q <= start_idx;
      off_q <= start_off;
      id_q  <= start_id;
    end
    if (take && (cnt_q == off_q)) word_q <= beat_data;
  end

  assign busy      = (st_q == FILL_BEATS);
  assign line_idx  = idx_q;
  assign beat_we   = take;
  assign beat_off  = cnt_q;
  assign last      = take && (cnt_q == LAST_OFF);
  assign miss_id   = id_q;
  assign miss_word = (off_q == LAST_OFF) ? beat_data : word_q;

  // R6
  single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == FILL_IDLE));

  // R3
  fill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (st_q == FILL_IDLE) && (cnt_q == '0));
endmodule

// File: rtl/nb_dcache.sv
module nb_dcache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_beat_valid,
  input  logic [DATA_W-1:0] fill_beat_data,
  output logic              cm_wr_valid,
  output logic [ADDR_W-1:0] cm_wr_addr,
  output logic [DATA_W-1:0] cm_wr_data,
  output logic              nc_valid,
  output logic              nc_write,
  output logic [ADDR_W-1:0] nc_addr,
  output logic [DATA_W-1:0] nc_wdata,
  input  logic [DATA_W-1:0] nc_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [OFF_W-1:0]  a_off;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_valid;
  logic [DATA_W-1:0] lk_data;
  logic              busy, last, beat_we;
  logic [IDX_W-1:0]  fill_idx;
  logic [OFF_W-1:0]  beat_off;
  logic [ID_W-1:0]   miss_id;
  logic [DATA_W-1:0] miss_word;
  logic              hit, same_line, stall, acc, ld_miss, st_hit;

  assign a_off = req_addr[OFF_W-1:0];
  assign a_idx = req_addr[OFF_W +: IDX_W];
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

  ndc_arrays #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_arrays (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(a_idx), .lk_off(a_off), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_data(lk_data),
    .st_we(st_hit), .st_idx(a_idx), .st_off(a_off), .st_data(req_wdata),
    .fb_we(beat_we), .fb_idx(fill_idx), .fb_off(beat_off), .fb_data(fill_beat_data),
    .al_we(ld_miss), .al_idx(a_idx), .al_tag(a_tag),
    .sv_we(last), .sv_idx(fill_idx)
  );

  ndc_fill #(.WORDS(WORDS), .IDX_W(IDX_W), .ID_W(ID_W), .DATA_W(DATA_W)) i_fill (
    .clk(clk), .rst_n(rst_n),
    .start(ld_miss), .start_idx(a_idx), .start_off(a_off), .start_id(req_id),
    .beat_valid(fill_beat_valid), .beat_data(fill_beat_data),
    .busy(busy), .line_idx(fill_idx), .beat_we(beat_we), .beat_off(beat_off),
    .last(last), .miss_id(miss_id), .miss_word(miss_word)
  );

  // lookup and hold-off
  assign hit       = lk_valid && (lk_tag == a_tag);
  assign same_line = busy && (a_idx == fill_idx);
  assign stall     = last || (busy && req_cacheable && (same_line || (!req_write && !hit)));
  assign req_ready = !stall;
  assign acc       = req_valid && req_ready;
  assign ld_miss   = acc && req_cacheable && !req_write && !hit;
  assign st_hit    = acc && req_cacheable && req_write && hit;

  // memory ports
  assign fill_req    = ld_miss;
  assign fill_addr   = {a_tag, a_idx, {OFF_W{1'b0}}};
  assign cm_wr_valid = acc && req_cacheable && req_write;
  assign cm_wr_addr  = req_addr;
  assign cm_wr_data  = req_wdata;
  assign nc_valid    = acc && !req_cacheable;
  assign nc_write    = req_write;
  assign nc_addr     = req_addr;
  assign nc_wdata    = req_wdata;

  // response stage
  logic              rsp_v_q, rsp_v_d;
  logic              rsp_nc_q, rsp_nc_d;
  logic [ID_W-1:0]   rsp_id_q, rsp_id_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  always_comb begin
    rsp_v_d    = last || (acc && !req_write && (hit || !req_cacheable));
    rsp_nc_d   = !last && !req_cacheable;
    rsp_id_d   = last ? miss_id : req_id;
    rsp_data_d = last ? miss_word : lk_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_v_q <= 1'b0;
    else        rsp_v_q <= rsp_v_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_v_d) begin
      rsp_nc_q   <= rsp_nc_d;
      rsp_id_q   <= rsp_id_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_id    = rsp_id_q;
  assign rsp_rdata = rsp_nc_q ? nc_rdata : rsp_data_q;

  // R3
  fill_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> busy);

  // R4
  miss_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (rsp_valid && (rsp_id == $past(miss_id))));
endmodule

// File: tb/test_nb_dcache.sv
`timescale 1ns/1ps
module test_nb_dcache;
  localparam int GAP = 3;

  typedef struct packed {
    logic        wr;
    logic        cch;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [3:0]  id;
    logic [31:0] exp;
    logic        fill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 12'h010, 32'h0,         4'd1, 32'hC000_0010, 1'b1},
    '{1'b0, 1'b1, 12'h021, 32'h0,         4'd2, 32'hC000_0021, 1'b1},
    '{1'b0, 1'b0, 12'h300, 32'h0,         4'd3, 32'h5000_0300, 1'b0},
    '{1'b0, 1'b1, 12'h012, 32'h0,         4'd4, 32'hC000_0012, 1'b0},
    '{1'b1, 1'b1, 12'h013, 32'hDEAD_BEEF, 4'd0, 32'h0,         1'b0},
    '{1'b0, 1'b1, 12'h013, 32'h0,         4'd5, 32'hDEAD_BEEF, 1'b0},
    '{1'b1, 1'b1, 12'h044, 32'h1111_2222, 4'd0, 32'h0,         1'b0},
    '{1'b0, 1'b1, 12'h044, 32'h0,         4'd6, 32'h1111_2222, 1'b1},
    '{1'b1, 1'b0, 12'h301, 32'h3333_4444, 4'd0, 32'h0,         1'b0},
    '{1'b0, 1'b0, 12'h301, 32'h0,         4'd7, 32'h3333_4444, 1'b0},
    '{1'b0, 1'b1, 12'h022, 32'h0,         4'd8, 32'hC000_0022, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_cacheable;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_id;
  logic        rsp_valid;
  logic [3:0]  rsp_id;
  logic [31:0] rsp_rdata;
  logic        fill_req;
  logic [11:0] fill_addr;
  logic        fill_beat_valid;
  logic [31:0] fill_beat_data;
  logic        cm_wr_valid;
  logic [11:0] cm_wr_addr;
  logic [31:0] cm_wr_data;
  logic        nc_valid, nc_write;
  logic [11:0] nc_addr;
  logic [31:0] nc_wdata, nc_rdata;

  always #4 clk = ~clk;

  nb_dcache i_nb_dcache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cacheable(req_cacheable), .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
    .cm_wr_valid(cm_wr_valid), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
    .nc_valid(nc_valid), .nc_write(nc_write), .nc_addr(nc_addr), .nc_wdata(nc_wdata),
    .nc_rdata(nc_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cmem  [4096];
  logic [31:0] ncmem [4096];
  logic [31:0] exp_data [16];
  logic        exp_set  [16];
  logic [3:0]  log_id  [64];
  logic [31:0] log_dat [64];
  int          log_n = 0;
  logic        a_fill, a_cwr, a_nc;
  logic [11:0] a_faddr;
  int          a_seen;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory models
  logic        f_act = 1'b0;
  logic        fb_last = 1'b0;
  logic [11:0] f_base;
  int          f_gap, f_beat;
  initial begin
    fill_beat_valid = 1'b0;
    fill_beat_data  = '0;
    nc_rdata        = '0;
    forever begin
      @(posedge clk);
      if (fill_req) begin
        f_act <= 1'b1; f_base <= fill_addr; f_gap <= GAP; f_beat <= 0;
        fill_beat_valid <= 1'b0; fb_last <= 1'b0;
      end else if (f_act) begin
        if (f_gap > 0) begin
          f_gap <= f_gap - 1;
          fill_beat_valid <= 1'b0;
        end else begin
          fill_beat_valid <= 1'b1;
          fill_beat_data  <= cmem[12'(f_base + 12'(f_beat))];
          fb_last <= (f_beat == 3);
          f_beat  <= f_beat + 1;
          if (f_beat == 3) f_act <= 1'b0;
        end
      end else begin
        fill_beat_valid <= 1'b0;
        fb_last <= 1'b0;
      end
      if (cm_wr_valid) cmem[cm_wr_addr] <= cm_wr_data;
      if (nc_valid) begin
        if (nc_write) ncmem[nc_addr] <= nc_wdata;
        else          nc_rdata <= ncmem[nc_addr];
      end
    end
  end

  // response log and final-beat hold-off monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid && log_n < 64) begin
      log_id[log_n]  = rsp_id;
      log_dat[log_n] = rsp_rdata;
      log_n++;
    end
    #2;
    if (rst_n && fill_beat_valid && fb_last)
      chk(req_ready == 1'b0, "R5 ready low on final beat", 32'(req_ready), 32'h0);
  end

  function automatic int pos_of(input logic [3:0] id);
    for (int k = 0; k < log_n; k++) if (log_id[k] == id) return k;
    return -1;
  endfunction

  task automatic issue(input logic wr, input logic cch, input logic [11:0] addr,
                       input logic [31:0] wd, input logic [3:0] id, output int waits);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cacheable = cch;
    req_addr = addr; req_wdata = wd; req_id = id;
    if (!wr) begin exp_data[id] = 32'h0; exp_set[id] = 1'b1; end
    waits = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; waits++;
    end
    a_fill = fill_req; a_faddr = fill_addr; a_cwr = cm_wr_valid; a_nc = nc_valid; a_seen = log_n;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w;
    for (int k = 0; k < 4096; k++) begin
      cmem[k]  = 32'hC000_0000 | 32'(k);
      ncmem[k] = 32'h5000_0000 | 32'(k);
    end
    for (int k = 0; k < 16; k++) begin exp_set[k] = 1'b0; exp_data[k] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cacheable = 1'b0;
    req_addr = '0; req_wdata = '0; req_id = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].cch, VECS[i].addr, VECS[i].wdata, VECS[i].id, w);
      if (!VECS[i].wr) exp_data[VECS[i].id] = VECS[i].exp;
      chk(a_fill == VECS[i].fill, "R1 R3 R10 fill launch", 32'(a_fill), 32'(VECS[i].fill));
      if (VECS[i].fill)
        chk(a_faddr == {VECS[i].addr[11:2], 2'b00}, "R3 line base address", 32'(a_faddr),
            32'({VECS[i].addr[11:2], 2'b00}));
      chk(a_cwr == (VECS[i].wr && VECS[i].cch), "R9 R10 write-through", 32'(a_cwr),
          32'(VECS[i].wr && VECS[i].cch));
      chk(a_nc == !VECS[i].cch, "R8 uncached port", 32'(a_nc), 32'(!VECS[i].cch));
    end
    idle();
    repeat (20) @(posedge clk);

    // hit under miss, then second miss
    issue(1'b0, 1'b1, 12'h080, 32'h0, 4'd9, w);
    exp_data[9] = 32'hC000_0080;
    chk(a_fill == 1'b1, "R3 miss launches fill", 32'(a_fill), 32'h1);
    issue(1'b0, 1'b1, 12'h011, 32'h0, 4'd10, w);
    exp_data[10] = 32'hC000_0011;
    chk(w == 0, "R2 hit during fill not stalled", 32'(w), 32'h0);
    issue(1'b0, 1'b1, 12'h0C4, 32'h0, 4'd11, w);
    exp_data[11] = 32'hC000_00C4;
    chk(w > 0, "R6 second miss held off", 32'(w), 32'h1);
    chk(a_fill == 1'b1, "R6 released miss launches fill", 32'(a_fill), 32'h1);
    chk(pos_of(4'd9) >= 0 && pos_of(4'd9) < a_seen, "R6 released after first fill answered",
        32'(pos_of(4'd9)), 32'(a_seen - 1));
    issue(1'b0, 1'b0, 12'h302, 32'h0, 4'd12, w);
    exp_data[12] = 32'h5000_0302;
    chk(w == 0, "R8 uncached during fill not stalled", 32'(w), 32'h0);
    chk(a_nc == 1'b1, "R8 uncached access issued", 32'(a_nc), 32'h1);
    issue(1'b1, 1'b1, 12'h0C5, 32'hABCD_0000, 4'd0, w);
    chk(w > 0, "R7 store to line under fill held off", 32'(w), 32'h1);
    chk(a_cwr == 1'b1 && a_fill == 1'b0, "R9 store after fill writes through", 32'(a_cwr), 32'h1);
    issue(1'b0, 1'b1, 12'h0C5, 32'h0, 4'd13, w);
    exp_data[13] = 32'hABCD_0000;
    chk(a_fill == 1'b0, "R4 filled line now hits", 32'(a_fill), 32'h0);
    idle();
    repeat (20) @(posedge clk);

    // ordering and data by ID
    chk(pos_of(4'd10) < pos_of(4'd9), "R11 younger hit answered before missed load",
        32'(pos_of(4'd10)), 32'(pos_of(4'd9)));
    chk(log_n == 13, "R11 one response per load", 32'(log_n), 32'd13);
    for (int k = 0; k < log_n; k++) begin
      chk(exp_set[log_id[k]] == 1'b1, "R11 response ID belongs to a load", 32'(log_id[k]), 32'h1);
      chk(log_dat[k] == exp_data[log_id[k]], "R2 R4 R8 response data", log_dat[k],
          exp_data[log_id[k]]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule